// File: doc/BRIEF.md
# Addressable Multi-Drop Scan Gateway

This block sits on a shared five-wire boundary-scan bus and connects one board's local scan paths to that bus when a controller asks for it. Many boards hang on the same bus, so each gateway must know when it is being spoken to. The controller runs an address scan that carries one 8-bit value. Each gateway compares that value with the slot address strapped on its backplane pins, with a programmable unit-type address and with a programmable group address. The result puts the gateway in one of four modes: deselected, individually selected, group selected or broadcast.

Every gateway always runs its own TAP state machine and instruction register, so a deselected board still sees the next address scan. Once selected, it passes the bus TMS to the local paths enabled in its path-select register. Those paths are chained in series behind the gateway's own scan register. The gateway drives the shared TDO line only when it alone is addressed. In group and broadcast modes many boards shift the same stimulus at once while their TDO drivers stay off. An enable output then tells a neighbouring compare unit to check the scan-out data locally.

Top module: `scan_gateway`

## Requirements
- R1: An asynchronous low on `trstN`, or one rising TCK edge spent in Test-Logic-Reset, clears the selection mode (active and pending), the path-select register and both programmable addresses to zero, and loads the instruction register with all ones (bypass).
- R2: An address scan whose value equals `slotAddr` selects the block individually. While individually selected, `tdoEn` is high in every Shift-DR and Shift-IR cycle and low in every other state.
- R3: The address value 8'hFF selects broadcast mode. In broadcast mode `tdoEn` stays low for whole scans.
- R4: A nonzero address value equal to the unit-type register or the group register (and not equal to the slot address or 8'hFF) selects group mode, with `tdoEn` held low. Slot match takes priority over broadcast, and broadcast over type/group.
- R5: The address is evaluated at Update-DR of the address scan. The new mode takes effect on entry to the next Capture-DR or Capture-IR. The rest of the current scan, and the following Run-Test/Idle, keep the old mode.
- R6: The type, group and path-select registers are written at Update-DR of their own scan only while the block is in some selected mode. A write scan made while deselected leaves them unchanged.
- R7: The serial chain runs from `tdi` through the gateway's own register (the instruction register in Shift-IR, the selected data register otherwise), then through each active local path in ascending index order, to `tdo`. An active path is a path whose select bit is set while the block is selected. The bypass register is one bit long.
- R8: Each inactive local path gets `pathTms` low, which parks it in Run-Test/Idle. An active path gets the bus `tms` unchanged.
- R9: The instruction register is 8 bits long, shifted LSB first, and captures 8'h01. Opcodes: 8'h0A address scan, 8'h0B type register, 8'h0C group register, 8'h0D path select. Every other code selects bypass.
- R10: Capture-DR loads the address register with `slotAddr`, the type and group registers with their current contents, the path register with the path-select bits, and bypass with 0. Data is shifted LSB first.
- R11: An address value that matches nothing deselects the block. The value 8'h00 never matches the type or group register.
- R12: `cmpEn` is high exactly in Shift-DR cycles while the block is in group or broadcast mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Bus test clock |
| trstN | input | 1 | Bus test reset, asynchronous, active low |
| tms | input | 1 | Bus mode select |
| tdi | input | 1 | Bus serial data in |
| tdo | output | 1 | Serial data toward the bus, changes on falling TCK |
| tdoEn | output | 1 | Drive enable for the shared TDO line |
| slotAddr | input | ADDR_W | Slot address from backplane straps |
| pathTms | output | NUM_PATHS | Mode select per local scan path |
| pathTdi | output | NUM_PATHS | Serial data into each local path |
| pathTdo | input | NUM_PATHS | Serial data back from each local path |
| cmpEn | output | 1 | Enable toward the local compare unit |

## Verification
The assertions watch on every cycle that TDO is driven only in a shift state and never in group or broadcast mode. They also check that the compare enable is confined to Shift-DR, that the selection mode changes only on entry to Capture or after reset, and that no local path sees TMS high while the block is deselected or the bus TMS is low. The address decoding and its priorities, the one-scan delay before a new selection applies, and the refusal of register writes while deselected all depend on sequences of scans, so only the bench scenarios show them. The same holds for the path-chain order and length, which the bench measures from the delay of a shifted pattern.

// File: rtl/gw_pkg.sv
package gw_pkg;

  typedef enum logic [3:0] {
    TAP_RESET, TAP_IDLE,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SHIFT_DR, TAP_EXIT1_DR, TAP_PAUSE_DR, TAP_EXIT2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SHIFT_IR, TAP_EXIT1_IR, TAP_PAUSE_IR, TAP_EXIT2_IR, TAP_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    MODE_NONE, MODE_SINGLE, MODE_GROUP, MODE_BCAST
  } sel_mode_e;

  typedef enum logic [2:0] {
    DR_BYPASS, DR_ADDR, DR_TYPE, DR_GROUP, DR_PATH
  } dr_sel_e;

  // Control-to-datapath strobes; each is true while the TAP sits in that state
  typedef struct packed {
    logic    inReset;
    logic    captureDr;
    logic    shiftDr;
    logic    updateDr;
    logic    shiftIr;
    logic    enterCapture;
    dr_sel_e drSel;
  } gw_strobe_t;

endpackage

// File: rtl/gw_tap_ctrl.sv
module gw_tap_ctrl
  import gw_pkg::*;
#(
  parameter int IR_W = 8,
  parameter logic [IR_W-1:0] OP_ADDR  = 8'h0A,
  parameter logic [IR_W-1:0] OP_TYPE  = 8'h0B,
  parameter logic [IR_W-1:0] OP_GROUP = 8'h0C,
  parameter logic [IR_W-1:0] OP_PATH  = 8'h0D
) (
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  input  logic       tdi,
  output gw_strobe_t strobe,
  output logic       irBit,
  output tap_state_e tapState
);

  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

  tap_state_e stateNext;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irHold;
  dr_sel_e drSel;

  always_comb begin
    stateNext = tapState;
    case (tapState)
      TAP_RESET:    stateNext = tms ? TAP_RESET    : TAP_IDLE;
      TAP_IDLE:     stateNext = tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_DR:   stateNext = tms ? TAP_SEL_IR   : TAP_CAP_DR;
      TAP_CAP_DR:   stateNext = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_SHIFT_DR: stateNext = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_EXIT1_DR: stateNext = tms ? TAP_UPD_DR   : TAP_PAUSE_DR;
      TAP_PAUSE_DR: stateNext = tms ? TAP_EXIT2_DR : TAP_PAUSE_DR;
      TAP_EXIT2_DR: stateNext = tms ? TAP_UPD_DR   : TAP_SHIFT_DR;
      TAP_UPD_DR:   stateNext = tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_IR:   stateNext = tms ? TAP_RESET    : TAP_CAP_IR;
      TAP_CAP_IR:   stateNext = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_SHIFT_IR: stateNext = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_EXIT1_IR: stateNext = tms ? TAP_UPD_IR   : TAP_PAUSE_IR;
      TAP_PAUSE_IR: stateNext = tms ? TAP_EXIT2_IR : TAP_PAUSE_IR;
      TAP_EXIT2_IR: stateNext = tms ? TAP_UPD_IR   : TAP_SHIFT_IR;
      TAP_UPD_IR:   stateNext = tms ? TAP_SEL_DR   : TAP_IDLE;
      default:      stateNext = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) tapState <= TAP_RESET;
    else        tapState <= stateNext;
  end

  // Instruction register: shift stage and held stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= '0;
      irHold  <= '1;
    end else begin
      case (tapState)
        TAP_RESET:    irHold  <= '1;
        TAP_CAP_IR:   irShift <= IR_CAPTURE;
        TAP_SHIFT_IR: irShift <= {tdi, irShift[IR_W-1:1]};
        TAP_UPD_IR:   irHold  <= irShift;
        default:      ;
      endcase
    end
  end

  always_comb begin
    if      (irHold == OP_ADDR)  drSel = DR_ADDR;
    else if (irHold == OP_TYPE)  drSel = DR_TYPE;
    else if (irHold == OP_GROUP) drSel = DR_GROUP;
    else if (irHold == OP_PATH)  drSel = DR_PATH;
    else                         drSel = DR_BYPASS;
  end

  assign irBit = irShift[0];

  assign strobe.inReset      = (tapState == TAP_RESET);
  assign strobe.captureDr    = (tapState == TAP_CAP_DR);
  assign strobe.shiftDr      = (tapState == TAP_SHIFT_DR);
  assign strobe.updateDr     = (tapState == TAP_UPD_DR);
  assign strobe.shiftIr      = (tapState == TAP_SHIFT_IR);
  assign strobe.enterCapture = ((tapState == TAP_SEL_DR) || (tapState == TAP_SEL_IR)) && !tms;
  assign strobe.drSel        = drSel;

endmodule

// File: rtl/gw_datapath.sv
module gw_datapath
  import gw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_PATHS = 3,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = '1
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  logic                 tms,
  input  logic                 tdi,
  input  gw_strobe_t           strobe,
  input  logic                 irBit,
  input  logic [ADDR_W-1:0]    slotAddr,
  input  logic [NUM_PATHS-1:0] pathTdo,
  output logic [NUM_PATHS-1:0] pathTms,
  output logic [NUM_PATHS-1:0] pathTdi,
  output logic                 tdo,
  output logic                 tdoEn,
  output logic                 cmpEn,
  output sel_mode_e            modeActive,
  output logic [NUM_PATHS-1:0] pathSel
);

  localparam int DR_W = (ADDR_W > NUM_PATHS) ? ADDR_W : NUM_PATHS;

  sel_mode_e modePend;
  sel_mode_e matchMode;
  logic [ADDR_W-1:0] typeAddr;
  logic [ADDR_W-1:0] groupAddr;
  logic [DR_W-1:0] drShift;
  logic [DR_W-1:0] drNext;
  logic [DR_W-1:0] drUp;
  logic [DR_W-1:0] capVal;
  logic [ADDR_W-1:0] shVal;
  logic [NUM_PATHS-1:0] pathActive;
  logic [NUM_PATHS:0] link;
  logic selected;
  int drLen;

  assign selected = (modeActive != MODE_NONE);
  assign shVal    = drShift[ADDR_W-1:0];
  assign drUp     = drShift >> 1;

  always_comb begin
    case (strobe.drSel)
      DR_ADDR, DR_TYPE, DR_GROUP: drLen = ADDR_W;
      DR_PATH:                    drLen = NUM_PATHS;
      default:                    drLen = 1;
    endcase
  end

  // Shift toward bit 0, new bit enters at the top of the active length
  always_comb begin
    drNext = '0;
    for (int k = 0; k < DR_W; k++) begin
      if (k == drLen - 1)     drNext[k] = tdi;
      else if (k < drLen - 1) drNext[k] = drUp[k];
    end
  end

  always_comb begin
    capVal = '0;
    case (strobe.drSel)
      DR_ADDR:  capVal[ADDR_W-1:0]    = slotAddr;
      DR_TYPE:  capVal[ADDR_W-1:0]    = typeAddr;
      DR_GROUP: capVal[ADDR_W-1:0]    = groupAddr;
      DR_PATH:  capVal[NUM_PATHS-1:0] = pathSel;
      default:  capVal = '0;
    endcase
  end

  // Address decode with slot > broadcast > type/group priority
  always_comb begin
    if (shVal == slotAddr)
      matchMode = MODE_SINGLE;
    else if (shVal == BCAST_ADDR)
      matchMode = MODE_BCAST;
    else if ((shVal != '0) && ((shVal == typeAddr) || (shVal == groupAddr)))
      matchMode = MODE_GROUP;
    else
      matchMode = MODE_NONE;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      modeActive <= MODE_NONE;
      modePend   <= MODE_NONE;
      typeAddr   <= '0;
      groupAddr  <= '0;
      pathSel    <= '0;
      drShift    <= '0;
    end else if (strobe.inReset) begin
      modeActive <= MODE_NONE;
      modePend   <= MODE_NONE;
      typeAddr   <= '0;
      groupAddr  <= '0;
      pathSel    <= '0;
    end else begin
      if (strobe.enterCapture) modeActive <= modePend;
      if (strobe.captureDr)    drShift <= capVal;
      if (strobe.shiftDr)      drShift <= drNext;
      if (strobe.updateDr) begin
        case (strobe.drSel)
          DR_ADDR:  modePend <= matchMode;
          DR_TYPE:  if (selected) typeAddr  <= shVal;
          DR_GROUP: if (selected) groupAddr <= shVal;
          DR_PATH:  if (selected) pathSel   <= drShift[NUM_PATHS-1:0];
          default:  ;
        endcase
      end
    end
  end

  // Local path chain: gateway register first, then active paths in index order
  assign link[0] = strobe.shiftIr ? irBit : drShift[0];

  for (genvar gi = 0; gi < NUM_PATHS; gi++) begin : g_path
    assign pathActive[gi] = selected && pathSel[gi];
    assign pathTms[gi]    = pathActive[gi] && tms;
    assign pathTdi[gi]    = link[gi];
    assign link[gi+1]     = pathActive[gi] ? pathTdo[gi] : link[gi];
  end

  // Bus-facing outputs change on the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
      cmpEn <= 1'b0;
    end else begin
      tdo   <= link[NUM_PATHS];
      tdoEn <= (strobe.shiftDr || strobe.shiftIr) && (modeActive == MODE_SINGLE);
      cmpEn <= strobe.shiftDr && ((modeActive == MODE_GROUP) || (modeActive == MODE_BCAST));
    end
  end

endmodule

// File: rtl/scan_gateway.sv
module scan_gateway
  import gw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_PATHS = 3,
  parameter int IR_W = 8,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 8'hFF,
  parameter logic [IR_W-1:0] OP_ADDR  = 8'h0A,
  parameter logic [IR_W-1:0] OP_TYPE  = 8'h0B,
  parameter logic [IR_W-1:0] OP_GROUP = 8'h0C,
  parameter logic [IR_W-1:0] OP_PATH  = 8'h0D
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  logic                 tms,
  input  logic                 tdi,
  output logic                 tdo,
  output logic                 tdoEn,
  input  logic [ADDR_W-1:0]    slotAddr,
  output logic [NUM_PATHS-1:0] pathTms,
  output logic [NUM_PATHS-1:0] pathTdi,
  input  logic [NUM_PATHS-1:0] pathTdo,
  output logic                 cmpEn
);

  gw_strobe_t strobe;
  logic irBit;
  tap_state_e tapState;
  sel_mode_e modeActive;
  logic [NUM_PATHS-1:0] pathSel;

  gw_tap_ctrl #(
    .IR_W(IR_W), .OP_ADDR(OP_ADDR), .OP_TYPE(OP_TYPE),
    .OP_GROUP(OP_GROUP), .OP_PATH(OP_PATH)
  ) u_ctrl (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .strobe(strobe), .irBit(irBit), .tapState(tapState)
  );

  gw_datapath #(
    .ADDR_W(ADDR_W), .NUM_PATHS(NUM_PATHS), .BCAST_ADDR(BCAST_ADDR)
  ) u_dp (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .strobe(strobe), .irBit(irBit), .slotAddr(slotAddr),
    .pathTdo(pathTdo), .pathTms(pathTms), .pathTdi(pathTdi),
    .tdo(tdo), .tdoEn(tdoEn), .cmpEn(cmpEn),
    .modeActive(modeActive), .pathSel(pathSel)
  );

endmodule

// File: rtl/gw_checker.sv
module gw_checker
  import gw_pkg::*;
#(
  parameter int NUM_PATHS = 3
) (
  input logic                 tck,
  input logic                 trstN,
  input logic                 tms,
  input logic                 tdoEn,
  input logic                 cmpEn,
  input logic [NUM_PATHS-1:0] pathTms,
  input tap_state_e           tapState,
  input sel_mode_e            modeActive
);

  p_tdo_in_shift_r2: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> ((tapState == TAP_SHIFT_DR) || (tapState == TAP_SHIFT_IR)));

  p_bcast_no_tdo_r3: assert property (@(posedge tck) disable iff (!trstN)
    (modeActive == MODE_BCAST) |-> !tdoEn);

  p_group_no_tdo_r4: assert property (@(posedge tck) disable iff (!trstN)
    (modeActive == MODE_GROUP) |-> !tdoEn);

  p_mode_hold_r5: assert property (@(posedge tck) disable iff (!trstN)
    ((tapState != TAP_SEL_DR) && (tapState != TAP_SEL_IR) && (tapState != TAP_RESET))
      |=> $stable(modeActive));

  p_park_idle_r8: assert property (@(posedge tck) disable iff (!trstN)
    ((modeActive == MODE_NONE) || !tms) |-> (pathTms == '0));

  p_cmp_dr_only_r12: assert property (@(posedge tck) disable iff (!trstN)
    cmpEn |-> ((tapState == TAP_SHIFT_DR) && (modeActive != MODE_SINGLE)));

endmodule

bind scan_gateway gw_checker #(.NUM_PATHS(NUM_PATHS)) u_chk (
  .tck(tck), .trstN(trstN), .tms(tms), .tdoEn(tdoEn), .cmpEn(cmpEn),
  .pathTms(pathTms), .tapState(tapState), .modeActive(modeActive)
);

// File: tb/tb_scan_gateway.sv
module tb_scan_gateway;

  localparam int PERIOD = 10;
  localparam int IR_W = 8;
  localparam logic [7:0] SLOT = 8'h5A;
  localparam logic [7:0] OPC_ADDR = 8'h0A, OPC_TYPE = 8'h0B, OPC_GROUP = 8'h0C,
                         OPC_PATH = 8'h0D, OPC_BYP = 8'hFF;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdoEn, cmpEn;
  logic [2:0] pathTms, pathTdi, pathTdo;

  int checkCount = 0;
  int failCount = 0;

  logic sTdo, sEn, sCmp;
  logic [2:0] sPathTms;
  logic [31:0] lastOut;
  logic enAll, enAny, cmpAll, cmpAny;

  always #(PERIOD/2) tck = ~tck;

  scan_gateway dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .slotAddr(SLOT), .pathTms(pathTms), .pathTdi(pathTdi), .pathTdo(pathTdo),
    .cmpEn(cmpEn)
  );

  // Local path models: plain delay lines of 2, 3 and 4 stages
  logic [1:0] p0 = '0;
  logic [2:0] p1 = '0;
  logic [3:0] p2 = '0;
  always @(posedge tck) begin
    p0 <= {p0[0], pathTdi[0]};
    p1 <= {p1[1:0], pathTdi[1]};
    p2 <= {p2[2:0], pathTdi[2]};
  end
  assign pathTdo = {p2[3], p1[2], p0[1]};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One TCK cycle: drive after negedge, sample outputs after next negedge
  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    #1 sPathTms = pathTms;
    @(posedge tck);
    @(negedge tck);
    #1;
    sTdo = tdo;
    sEn = tdoEn;
    sCmp = cmpEn;
  endtask

  task automatic scanCore(input int n, input logic [31:0] data);
    lastOut = '0;
    enAll = 1'b1; enAny = 1'b0; cmpAll = 1'b1; cmpAny = 1'b0;
    for (int i = 0; i < n; i++) begin
      lastOut[i] = sTdo;
      enAll &= sEn; enAny |= sEn;
      cmpAll &= sCmp; cmpAny |= sCmp;
      step(i == n - 1, data[i]);
    end
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic scanIr(input logic [7:0] code);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    scanCore(IR_W, {24'h0, code});
  endtask

  task automatic scanDr(input logic [31:0] data, input int n);
    step(1, 0); step(0, 0); step(0, 0);
    scanCore(n, data);
  endtask

  task automatic tReset();
    trstN = 1'b0; tms = 1'b1;
    repeat (3) @(negedge tck);
    #1;
    chk(tdoEn == 0 && cmpEn == 0, "R1 outputs in reset", {tdoEn, cmpEn}, 0);
    chk(pathTms == 3'b000, "R8 paths parked in reset", pathTms, 0);
    trstN = 1'b1;
    step(0, 0);
    scanIr(OPC_BYP);
    chk(!enAny, "R1 deselected after reset", enAny, 0);
  endtask

  task automatic tSingle();
    scanIr(OPC_ADDR);
    scanDr({24'h0, SLOT}, 8);
    chk(!enAny, "R5 selection not yet active", enAny, 0);
    scanIr(OPC_ADDR);
    chk(enAll, "R2 tdo driven in Shift-IR when single", enAll, 1);
    chk(lastOut[7:0] == 8'h01, "R9 IR capture value", lastOut[7:0], 8'h01);
    scanDr({24'h0, SLOT}, 8);
    chk(lastOut[7:0] == SLOT, "R10 slot address captured", lastOut[7:0], SLOT);
    chk(!cmpAny, "R12 no compare when single", cmpAny, 0);
  endtask

  task automatic tRegWrite();
    scanIr(OPC_TYPE);
    scanDr(32'h30, 8);
    chk(lastOut[7:0] == 8'h00, "R1 type register reset value", lastOut[7:0], 0);
    scanDr(32'h30, 8);
    chk(lastOut[7:0] == 8'h30, "R6 type register written", lastOut[7:0], 8'h30);
    scanIr(OPC_GROUP);
    scanDr(32'h42, 8);
    scanDr(32'h42, 8);
    chk(lastOut[7:0] == 8'h42, "R6 group register written", lastOut[7:0], 8'h42);
  endtask

  task automatic tGroup();
    scanIr(OPC_ADDR);
    scanDr(32'h42, 8);
    chk(enAll, "R5 old mode kept during address scan", enAll, 1);
    scanDr(32'h30, 8);
    chk(!enAny && cmpAll, "R4 group address gives group mode", {enAny, cmpAll}, 2'b01);
    scanDr({24'h0, SLOT}, 8);
    chk(!enAny && cmpAll, "R4 type address gives group mode", {enAny, cmpAll}, 2'b01);
    scanIr(OPC_ADDR);
    chk(enAll, "R2 individual access regained", enAll, 1);
  endtask

  task automatic tIgnore();
    scanDr(32'h77, 8);
    chk(enAll, "R5 deselect waits for next capture", enAll, 1);
    scanIr(OPC_TYPE);
    chk(!enAny, "R11 unmatched address deselects", enAny, 0);
    scanDr(32'h99, 8);
    scanIr(OPC_ADDR);
    scanDr({24'h0, SLOT}, 8);
    scanIr(OPC_TYPE);
    scanDr(32'h30, 8);
    chk(lastOut[7:0] == 8'h30, "R6 write ignored while deselected", lastOut[7:0], 8'h30);
  endtask

  task automatic tBroadcast();
    scanIr(OPC_ADDR);
    scanDr(32'hFF, 8);
    scanDr(32'hFF, 8);
    chk(!enAny, "R3 tdo off for whole broadcast scan", enAny, 0);
    chk(cmpAll, "R12 compare enabled in Shift-DR broadcast", cmpAll, 1);
    scanIr(OPC_BYP);
    chk(!enAny && !cmpAny, "R12 no compare in Shift-IR", {enAny, cmpAny}, 0);
    scanIr(OPC_ADDR);
    scanDr({24'h0, SLOT}, 8);
  endtask

  task automatic tPaths();
    logic [31:0] pat;
    pat = 32'h00B3_4E5D;
    scanIr(OPC_BYP);
    scanDr(pat, 16);
    for (int i = 1; i < 16; i++)
      chk(lastOut[i] == pat[i-1], "R7 bypass is one bit", lastOut[i], pat[i-1]);
    scanIr(OPC_PATH);
    scanDr(32'h5, 3);
    step(1, 0);
    chk(sPathTms == 3'b101, "R8 active paths follow tms", sPathTms, 3'b101);
    step(0, 0);
    chk(sPathTms == 3'b000, "R8 tms low passes through", sPathTms, 0);
    step(1, 0); step(1, 0); step(0, 0);
    scanIr(OPC_BYP);
    scanDr(pat, 24);
    for (int i = 7; i < 24; i++)
      chk(lastOut[i] == pat[i-7], "R7 chain through paths 0 and 2", lastOut[i], pat[i-7]);
  endtask

  task automatic tTlr();
    for (int i = 0; i < 5; i++) step(1, 0);
    step(1, 0);
    chk(sPathTms == 3'b000, "R1 path select cleared by TLR", sPathTms, 0);
    step(0, 0);
    scanIr(OPC_BYP);
    chk(!enAny, "R1 selection cleared by TLR", enAny, 0);
  endtask

  task automatic tZero();
    scanIr(OPC_ADDR);
    scanDr(32'h00, 8);
    scanDr(32'h00, 8);
    chk(!enAny && !cmpAny, "R11 zero address matches nothing", {enAny, cmpAny}, 0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge tck);
    failCount++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    @(negedge tck);
    #1;
    tReset();
    tSingle();
    tRegWrite();
    tGroup();
    tIgnore();
    tBroadcast();
    tPaths();
    tTlr();
    tZero();
    finishRun();
  end

endmodule